// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block sits on a two-wire control bus as a write-only slave. It owns two 16-bit configuration registers, a basic one that carries the operating mode and a voice/test one. A host writes a register by sending the device address, then the high data byte, then the low data byte. The block acknowledges each byte by pulling SDA low, and it commits the whole 16-bit word at once after the final acknowledge. Both register values are driven straight out as ports for the rest of the chip.

The device address has seven bits. The two upper bits both follow a strap pin, the next four bits are the constant pattern `1000`, and the lowest bit picks the register: 0 is basic, 1 is voice/test. The block turns the four-bit mode field of the basic register, together with two mute bits, into registered source selects for the mono speaker path and for the left and right headphone paths. Writing the basic register with its soft-reset bit set produces a one-cycle reset pulse for the downstream logic. The registers keep their values through that pulse.

SCL and SDA are synchronised to the system clock and edge-detected. START and STOP are recognised at any point in a transfer.

Top module: `tw_cfg_slave`

## Requirements
- R1: After a synchronous reset both registers read 0x0000, all three source selects are 0 (none), `sda_pull_low` is 0 and `soft_rst_pulse` is 0.
- R2: A byte after START equal to {S, S, 1, 0, 0, 0, r, 0} is acknowledged, where S is the `addr_strap` level, r is the register select and the final bit is R/W = write. Acknowledging means `sda_pull_low` is high during the ninth SCL clock.
- R3: An address byte whose upper six bits do not match, or whose R/W bit is 1 (read), is not acknowledged. The block then ignores the bus until the next START, and no register changes.
- R4: The two data bytes after a matched address are each acknowledged. The register chosen by r (0 = basic, 1 = voice/test) takes the value {first byte, second byte} only after the second acknowledge. A START in the middle of a transfer restarts address reception.
- R5: A register keeps its value unless a complete write to it finishes. A STOP or START after only the first data byte leaves both registers unchanged.
- R6: The source selects use the codes 0 none, 1 voice, 2 left audio, 3 right audio, 4 left+right mix, 5 voice plus left audio. They are given as (speaker, headphone left, headphone right) and are driven from basic bits 3:0, appearing one clock after the register changes. Mode 0 gives (0,0,0), 1 gives (0,0,0), 2 gives (1,0,0), 3 gives (0,1,1) and 4 gives (1,1,1).
- R7: Mode 5 gives (4,0,0), 6 gives (0,2,3), 7 gives (4,2,3), 8 gives (2,1,1), 9 gives (5,1,1) and 10 gives (1,2,2).
- R8: Modes 11 to 15 give (0,0,0).
- R9: Basic bit 13 set forces the speaker select to 0. Basic bit 14 set forces both headphone selects to 0. Both apply whatever the mode.
- R10: A completed write to the basic register with bit 4 set produces exactly one `soft_rst_pulse` cycle, and the register keeps the written value. A write with bit 4 clear produces no pulse.
- R11: Any byte after the second data byte of a transfer is not acknowledged, and it does not change the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 1 | Strap level copied into both upper address bits |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_pull_low | output | 1 | High to drive SDA low (acknowledge) |
| basic_cfg | output | 16 | Basic configuration register |
| voice_cfg | output | 16 | Voice/test configuration register |
| spk_src | output | 3 | Mono speaker source select |
| hpl_src | output | 3 | Left headphone source select |
| hpr_src | output | 3 | Right headphone source select |
| soft_rst_pulse | output | 1 | One-cycle soft reset for downstream logic |

## Verification
The embedded assertions check the following on every cycle:
- the acknowledge drive appears only in acknowledge phases and never while the bus is being ignored;
- a START always returns the engine to address reception;
- write strobes and soft-reset pulses last one cycle;
- registers hold between writes;
- the mute bits and undefined modes blank the selects on the next clock.

Some behaviour only the bench scenarios can show:
- the byte-level framing of a transfer;
- whether a particular address byte is acknowledged under each strap level;
- the full mode-to-route table;
- an aborted or restarted transfer leaving the registers alone;
- a trailing byte going unacknowledged.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;

  typedef enum logic [2:0] {
    SRC_NONE        = 3'd0,
    SRC_VOICE       = 3'd1,
    SRC_AUD_L       = 3'd2,
    SRC_AUD_R       = 3'd3,
    SRC_AUD_LR      = 3'd4,
    SRC_VOICE_AUD_L = 3'd5
  } src_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_DATA,
    ST_ACK_D,
    ST_SKIP
  } tw_state_t;

  localparam int MODE_W       = 4;
  localparam int SOFT_RST_BIT = 4;
  localparam int MUTE_SPK_BIT = 13;
  localparam int MUTE_HP_BIT  = 14;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int PW = STAGES + 1;

  logic [PW-1:0] scl_pipe;
  logic [PW-1:0] sda_pipe;

  // Idle bus level is high, so the pipes reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_in};
      sda_pipe <= {sda_pipe[PW-2:0], sda_in};
    end
  end

  logic scl_s, scl_d, sda_s, sda_d;
  assign scl_s = scl_pipe[PW-2];
  assign scl_d = scl_pipe[PW-1];
  assign sda_s = sda_pipe[PW-2];
  assign sda_d = sda_pipe[PW-1];

  assign sda_bit   = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/tw_rx_engine.sv
module tw_rx_engine
  import tw_cfg_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter logic [3:0]  ADDR_MID = 4'b1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  input  logic              sda_bit,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull_low,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [DATA_W-1:0] wr_data
);

  localparam int BYTES  = DATA_W / 8;
  localparam int BCNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [BCNT_W-1:0] LAST_BYTE = BCNT_W'(BYTES - 1);

  tw_state_t         state;
  logic [3:0]        bit_cnt;
  logic [BCNT_W-1:0] byte_cnt;
  logic [7:0]        shreg;
  logic [DATA_W-1:0] data_sr;
  logic              sel_q, pull_q, wr_q;

  logic byte_full, addr_hit;
  assign byte_full = (bit_cnt == 4'd8);
  assign addr_hit  = (shreg[7:6] == {strap, strap}) &&
                     (shreg[5:2] == ADDR_MID) && !shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      data_sr  <= '0;
      sel_q    <= 1'b0;
      pull_q   <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        pull_q   <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        pull_q <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && !byte_full) begin
              shreg   <= {shreg[6:0], sda_bit};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && byte_full) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sel_q  <= shreg[1];
                  pull_q <= 1'b1;
                  state  <= ST_ACK_A;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                data_sr <= {data_sr[DATA_W-9:0], shreg};
                pull_q  <= 1'b1;
                state   <= ST_ACK_D;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              state  <= ST_DATA;
            end
          end
          ST_ACK_D: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              if (byte_cnt == LAST_BYTE) begin
                wr_q  <= 1'b1;
                state <= ST_SKIP;
              end else begin
                byte_cnt <= byte_cnt + 1'b1;
                state    <= ST_DATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_low = pull_q;
  assign wr_en        = wr_q;
  assign wr_sel       = sel_q;
  assign wr_data      = data_sr;

  // R2
  ack_phase_chk: assert property (@(posedge clk) disable iff (rst)
    sda_pull_low |-> (state == ST_ACK_A || state == ST_ACK_D));

  // R3
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && !sda_pull_low));

  // R11
  skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_pull_low);

  // R4
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

endmodule

// File: rtl/tw_route_map.sv
module tw_route_map
  import tw_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              mute_spk,
  input  logic              mute_hp,
  output src_t              spk_src,
  output src_t              hpl_src,
  output src_t              hpr_src
);

  src_t spk_n, hpl_n, hpr_n;

  always_comb begin
    spk_n = SRC_NONE;
    hpl_n = SRC_NONE;
    hpr_n = SRC_NONE;
    case (mode)
      4'd2:  spk_n = SRC_VOICE;
      4'd3:  begin hpl_n = SRC_VOICE; hpr_n = SRC_VOICE; end
      4'd4:  begin spk_n = SRC_VOICE; hpl_n = SRC_VOICE; hpr_n = SRC_VOICE; end
      4'd5:  spk_n = SRC_AUD_LR;
      4'd6:  begin hpl_n = SRC_AUD_L; hpr_n = SRC_AUD_R; end
      4'd7:  begin spk_n = SRC_AUD_LR; hpl_n = SRC_AUD_L; hpr_n = SRC_AUD_R; end
      4'd8:  begin spk_n = SRC_AUD_L; hpl_n = SRC_VOICE; hpr_n = SRC_VOICE; end
      4'd9:  begin spk_n = SRC_VOICE_AUD_L; hpl_n = SRC_VOICE; hpr_n = SRC_VOICE; end
      4'd10: begin spk_n = SRC_VOICE; hpl_n = SRC_AUD_L; hpr_n = SRC_AUD_L; end
      default: ;
    endcase
    if (mute_spk) spk_n = SRC_NONE;
    if (mute_hp) begin
      hpl_n = SRC_NONE;
      hpr_n = SRC_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spk_src <= SRC_NONE;
      hpl_src <= SRC_NONE;
      hpr_src <= SRC_NONE;
    end else begin
      spk_src <= spk_n;
      hpl_src <= hpl_n;
      hpr_src <= hpr_n;
    end
  end

  // R9
  spk_mute_chk: assert property (@(posedge clk) disable iff (rst)
    mute_spk |=> (spk_src == SRC_NONE));

  // R9
  hp_mute_chk: assert property (@(posedge clk) disable iff (rst)
    mute_hp |=> (hpl_src == SRC_NONE && hpr_src == SRC_NONE));

  // R8
  undef_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode > 4'd10) |=> (spk_src == SRC_NONE && hpl_src == SRC_NONE && hpr_src == SRC_NONE));

endmodule

// File: rtl/tw_cfg_slave.sv
module tw_cfg_slave
  import tw_cfg_pkg::*;
#(
  parameter int         REG_W       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_MID    = 4'b1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_strap,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull_low,
  output logic [REG_W-1:0] basic_cfg,
  output logic [REG_W-1:0] voice_cfg,
  output logic [2:0]       spk_src,
  output logic [2:0]       hpl_src,
  output logic [2:0]       hpr_src,
  output logic             soft_rst_pulse
);

  localparam int NUM_REGS = 2;

  logic sda_bit, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, wr_sel;
  logic [REG_W-1:0] wr_data;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tw_rx_engine #(.DATA_W(REG_W), .ADDR_MID(ADDR_MID)) u_engine (
    .clk(clk), .rst(rst), .strap(addr_strap), .sda_bit(sda_bit),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_pull_low(sda_pull_low), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data)
  );

  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= '0;
      else if (wr_en && (wr_sel == 1'(g)))
        regs_q[g] <= wr_data;
    end

    // R5
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (wr_sel == 1'(g))) |=> $stable(regs_q[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) soft_rst_pulse <= 1'b0;
    else     soft_rst_pulse <= wr_en && !wr_sel && wr_data[SOFT_RST_BIT];
  end

  assign basic_cfg = regs_q[0];
  assign voice_cfg = regs_q[1];

  src_t spk_e, hpl_e, hpr_e;

  tw_route_map u_route (
    .clk(clk), .rst(rst),
    .mode(regs_q[0][MODE_W-1:0]),
    .mute_spk(regs_q[0][MUTE_SPK_BIT]),
    .mute_hp(regs_q[0][MUTE_HP_BIT]),
    .spk_src(spk_e), .hpl_src(hpl_e), .hpr_src(hpr_e)
  );

  assign spk_src = spk_e;
  assign hpl_src = hpl_e;
  assign hpr_src = hpr_e;

  // R10
  soft_bit_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_pulse |-> basic_cfg[SOFT_RST_BIT]);

  // R10
  soft_single_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_pulse |=> !soft_rst_pulse);

endmodule

// File: tb/tw_cfg_slave_bench.sv
module tw_cfg_slave_bench;
  import tw_cfg_pkg::*;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_low, soft_rst_pulse;
  logic [15:0] basic_cfg, voice_cfg;
  logic [2:0] spk_src, hpl_src, hpr_src;
  logic sda_line;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_low;

  tw_cfg_slave u_tw_cfg_slave (
    .clk(clk), .rst(rst), .addr_strap(strap), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .basic_cfg(basic_cfg), .voice_cfg(voice_cfg),
    .spk_src(spk_src), .hpl_src(hpl_src), .hpr_src(hpr_src),
    .soft_rst_pulse(soft_rst_pulse)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct packed {
    logic [15:0] b;
    logic [15:0] v;
    logic [2:0]  s;
    logic [2:0]  l;
    logic [2:0]  r;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic  chk_req = 1'b0;
  logic [15:0] sh_b = '0;
  logic [15:0] sh_v = '0;
  int soft_cycles = 0;
  int soft_rises  = 0;
  logic soft_prev = 1'b0;

  function automatic void chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  function automatic logic [8:0] model_routes(input logic [15:0] b);
    logic [2:0] s, l, r;
    s = 3'd0; l = 3'd0; r = 3'd0;
    case (b[3:0])
      4'd2:  s = 3'd1;
      4'd3:  begin l = 3'd1; r = 3'd1; end
      4'd4:  begin s = 3'd1; l = 3'd1; r = 3'd1; end
      4'd5:  s = 3'd4;
      4'd6:  begin l = 3'd2; r = 3'd3; end
      4'd7:  begin s = 3'd4; l = 3'd2; r = 3'd3; end
      4'd8:  begin s = 3'd2; l = 3'd1; r = 3'd1; end
      4'd9:  begin s = 3'd5; l = 3'd1; r = 3'd1; end
      4'd10: begin s = 3'd1; l = 3'd2; r = 3'd2; end
      default: ;
    endcase
    if (b[13]) s = 3'd0;
    if (b[14]) begin l = 3'd0; r = 3'd0; end
    return {s, l, r};
  endfunction

  // Monitor: pops an expected snapshot whenever the driver requests a compare.
  always @(negedge clk) begin
    if (soft_rst_pulse) soft_cycles++;
    if (soft_rst_pulse && !soft_prev) soft_rises++;
    soft_prev = soft_rst_pulse;
    if (chk_req && exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " basic"}, 32'(basic_cfg), 32'(e.b));
      chk({t, " voice"}, 32'(voice_cfg), 32'(e.v));
      chk({t, " spk"},   32'(spk_src),   32'(e.s));
      chk({t, " hpl"},   32'(hpl_src),   32'(e.l));
      chk({t, " hpr"},   32'(hpr_src),   32'(e.r));
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    logic [8:0] rt;
    rt = model_routes(sh_b);
    e.b = sh_b; e.v = sh_v; e.s = rt[8:6]; e.l = rt[5:3]; e.r = rt[2:0];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    wait_clks(4);
    chk_req = 1'b1;
    @(posedge clk);
    chk_req = 1'b0;
    wait_clks(2);
  endtask

  task automatic tw_start();
    sda_m = 1'b1; wait_clks(Q);
    scl_m = 1'b1; wait_clks(Q);
    sda_m = 1'b0; wait_clks(Q);
    scl_m = 1'b0; wait_clks(Q);
  endtask

  task automatic tw_stop();
    sda_m = 1'b0; wait_clks(Q);
    scl_m = 1'b1; wait_clks(Q);
    sda_m = 1'b1; wait_clks(Q);
  endtask

  task automatic tw_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clks(Q);
      scl_m = 1'b1; wait_clks(Q);
      scl_m = 1'b0; wait_clks(Q);
    end
    sda_m = 1'b1; wait_clks(Q);
    scl_m = 1'b1; wait_clks(Q / 2);
    @(negedge clk);
    acked = !sda_line;
    wait_clks(Q);
    scl_m = 1'b0; wait_clks(Q);
  endtask

  function automatic logic [6:0] dev_addr(input logic s, input logic r);
    return {s, s, 4'b1000, r};
  endfunction

  // Sends n bytes after START; bit i of exp_ack is the expected ACK of byte i.
  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] b3, input int n, input logic [3:0] exp_ack,
                       input string req, input bit do_stop);
    logic [7:0] bytes [4];
    bit a;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
    tw_start();
    for (int i = 0; i < n; i++) begin
      tw_byte(bytes[i], a);
      chk({req, " ack"}, 32'(a), 32'(exp_ack[i]));
    end
    if (do_stop) tw_stop();
    wait_clks(8);
  endtask

  task automatic reg_write(input logic r, input logic [15:0] d, input string req);
    frame({dev_addr(strap, r), 1'b0}, d[15:8], d[7:0], 8'h00, 3, 4'b0111, req, 1'b1);
    if (r) sh_v = d; else sh_b = d;
    expect_now(req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    int rises0;
    wait_clks(5);
    rst = 1'b0;
    wait_clks(3);
    @(negedge clk);
    // R1: reset state
    chk("R1 pull", 32'(sda_pull_low), 32'd0);
    chk("R1 soft", 32'(soft_rst_pulse), 32'd0);
    expect_now("R1");

    // R2 R4 R6: basic write under strap 0, voice write
    reg_write(1'b0, 16'h0002, "R2 R6 mode2");
    reg_write(1'b1, 16'hA5C3, "R4 voice");

    // R6 R7 R8: every mode code
    for (int m = 0; m < 16; m++) begin
      reg_write(1'b0, 16'(m), (m < 5) ? "R6 mode" : (m < 11) ? "R7 mode" : "R8 mode");
    end

    // R9: mutes over mode 7 and mode 9
    reg_write(1'b0, 16'h2007, "R9 spk mute");
    reg_write(1'b0, 16'h4007, "R9 hp mute");
    reg_write(1'b0, 16'h6009, "R9 both mute");
    reg_write(1'b0, 16'h0009, "R7 mode9");

    // R3: strap 1 with strap-0 address, and a read request
    strap = 1'b1;
    frame({dev_addr(1'b0, 1'b0), 1'b0}, 8'hFF, 8'hFF, 8'h00, 1, 4'b0000, "R3 addr miss", 1'b1);
    expect_now("R3 miss");
    frame({dev_addr(1'b1, 1'b0), 1'b1}, 8'h00, 8'h00, 8'h00, 1, 4'b0000, "R3 read", 1'b1);
    expect_now("R3 read");
    // R2: strap 1 address accepted
    reg_write(1'b0, 16'h0006, "R2 strap1");

    // R5: stop after first data byte
    frame({dev_addr(1'b1, 1'b1), 1'b0}, 8'h12, 8'h00, 8'h00, 2, 4'b0011, "R5 abort", 1'b1);
    expect_now("R5 abort");

    // R4 R5: repeated start after first data byte, then a full write
    frame({dev_addr(1'b1, 1'b0), 1'b0}, 8'h77, 8'h00, 8'h00, 2, 4'b0011, "R5 restart", 1'b0);
    reg_write(1'b0, 16'h0004, "R4 restart write");

    // R11: trailing byte not acknowledged
    frame({dev_addr(1'b1, 1'b1), 1'b0}, 8'h3C, 8'h96, 8'hE1, 4, 4'b0111, "R11 extra", 1'b1);
    sh_v = 16'h3C96;
    expect_now("R11 extra");

    // R10: soft reset pulse
    rises0 = soft_rises;
    reg_write(1'b0, 16'h0016, "R10 soft");
    chk("R10 one pulse", 32'(soft_rises), 32'(rises0 + 1));
    chk("R10 width", 32'(soft_cycles), 32'(soft_rises));
    reg_write(1'b0, 16'h0003, "R10 no soft");
    chk("R10 no pulse", 32'(soft_rises), 32'(rises0 + 1));
    chk("R1 pull idle", 32'(sda_pull_low), 32'd0);

    wait_clks(10);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule